// File: doc/BRIEF.md
# Receive Descriptor Writer

This block is the receive data mover of a scatter-gather DMA channel. When a packet arrives on its AXI4-Stream input it walks the linked list of descriptors, starting at the current pointer supplied by the register block. For each descriptor it writes a chunk of the packet into that descriptor's buffer through a simple word-wide memory master port. It then writes back a status word carrying start, end and done flags. On the last descriptor of the packet it also stores the sideband application words.

Register decoding and interrupt generation live elsewhere. The block reads the run and idle state and the current and tail pointers as inputs. It reports back through three single-cycle pulses: a pointer-advance pulse that carries the next pointer, a completion pulse for each finished packet, and an idle-set pulse.

A descriptor is nine 32-bit words at consecutive word addresses from its base byte address:

| Word | Content |
|------|---------|
| 0 | Next pointer |
| 1 | Buffer address |
| 2 | Control; bits 22:0 hold the chunk limit, counted in stream beats |
| 3 | Status |
| 4..8 | The five application words |

Each stream beat is one 32-bit word. Beat i of a chunk is written to the buffer address plus 4*i.

Top module: `rx_desc_writer`

## Requirements
- R1: While `run_i` is low or `idle_i` is high when a packet starts, every beat of that packet up to and including its last beat is accepted and discarded. It causes no memory access, no pulse and no pointer change.
- R2: If status bit 31 of a fetched descriptor is already set, `idle_set_o` pulses and nothing is written. The pointer is not advanced, and the rest of the packet is discarded.
- R3: The chunk written to a descriptor is the lesser of its control bits 22:0 and the beats still remaining in the packet. Beat i of the chunk goes to buffer address + 4*i.
- R4: Status bit 27 (start) is set only in the first descriptor used for a packet.
- R5: On the descriptor that takes the last beat, status bit 26 (end) is set. The five application words are written to words 4..8 before the status, and `done_o` pulses exactly once.
- R6: The status written to word 3 of every used descriptor has bit 31 set, its beat count in bits 22:0, and zero elsewhere. It is the last write made to that descriptor.
- R7: After each status write, `ptr_adv_o` pulses for one cycle with `next_ptr_o` equal to the fetched word 0. If the descriptor was the tail, `idle_set_o` pulses in the same cycle and any remaining beats of the packet are discarded.
- R8: `s_tready_o` is low during every descriptor read and every descriptor write-back.
- R9: The application words stored are the values on `app_words_i` while the first beat is presented. Later changes on that input have no effect.
- R10: After reset no memory request and no pulse is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Channel running |
| idle_i | input | 1 | Channel idle |
| cur_ptr_i | input | ADDR_W | Current descriptor byte address |
| tail_ptr_i | input | ADDR_W | Tail descriptor byte address |
| s_tvalid_i | input | 1 | Stream beat valid |
| s_tready_o | output | 1 | Stream beat accepted |
| s_tdata_i | input | 32 | Stream beat data |
| s_tlast_i | input | 1 | Last beat of packet |
| app_words_i | input | APP_N*32 | Sideband application words, word j in bits 32j+31:32j |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | Write when high, read when low |
| mem_addr_o | output | ADDR_W | Byte address, word aligned |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with acknowledge |
| mem_ack_i | input | 1 | Request completes this cycle |
| done_o | output | 1 | Packet completion pulse |
| idle_set_o | output | 1 | Set-idle pulse |
| ptr_adv_o | output | 1 | Current pointer update pulse |
| next_ptr_o | output | ADDR_W | New current pointer, valid with ptr_adv_o |

## Verification
The completion pulse and the idle-set pulse can fall in the same cycle. This happens when the last beat of a packet lands in the tail descriptor. The bench provokes it by sizing a packet to exactly fill the tail descriptor, and counts the cycles in which both pulses are high together; one such cycle is expected. The opposite cases are also judged by the pulse counts. Reaching the tail with beats remaining must give an idle-set pulse with no completion. A completed packet short of the tail must give a completion with no idle-set pulse.

// File: rtl/rxdw_pkg.sv
package rxdw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DROP, ST_FETCH, ST_DATA, ST_APP, ST_STAT, ST_ADV
  } rxdw_state_e;

  localparam int unsigned WORD_W    = 32;
  localparam int unsigned W_NEXT    = 0;
  localparam int unsigned W_BUF     = 1;
  localparam int unsigned W_CTRL    = 2;
  localparam int unsigned W_STAT    = 3;
  localparam int unsigned W_APP0    = 4;
  localparam int unsigned DONE_BIT  = 31;
  localparam int unsigned SOF_BIT   = 27;
  localparam int unsigned EOF_BIT   = 26;
endpackage

// File: rtl/rxdw_chunk_ctr.sv
module rxdw_chunk_ctr #(
  parameter int unsigned LEN_W = 23
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [LEN_W-1:0] limit_i,
  output logic [LEN_W-1:0] count_o,
  output logic             last_o
);
  logic [LEN_W-1:0] count_q;
  logic [LEN_W:0]   count_nxt;

  assign count_nxt = {1'b0, count_q} + {{LEN_W{1'b0}}, 1'b1};
  // true when the beat being taken now fills the chunk
  assign last_o    = count_nxt >= {1'b0, limit_i};
  assign count_o   = count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     count_q <= '0;
    else if (clr_i)  count_q <= '0;
    else if (inc_i)  count_q <= count_nxt[LEN_W-1:0];
  end
endmodule

// File: rtl/rxdw_app_store.sv
module rxdw_app_store #(
  parameter int unsigned APP_N  = 5,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned SEL_W = $clog2(APP_N)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cap_i,
  input  logic [APP_N*WORD_W-1:0] app_i,
  input  logic [SEL_W-1:0]        sel_i,
  output logic [WORD_W-1:0]       word_o
);
  localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(APP_N - 1);

  logic [WORD_W-1:0] words_q [APP_N];

  for (genvar g = 0; g < APP_N; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    words_q[g] <= '0;
      else if (cap_i) words_q[g] <= app_i[g*WORD_W +: WORD_W];
    end
  end

  assign word_o = (sel_i <= LAST_SEL) ? words_q[sel_i] : '0;
endmodule

// File: rtl/rxdw_seq.sv
module rxdw_seq
  import rxdw_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 23,
  parameter int unsigned APP_N  = 5,
  localparam int unsigned SEL_W = $clog2(APP_N),
  localparam int unsigned IDX_W = (SEL_W > 2) ? SEL_W : 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              idle_i,
  input  logic [ADDR_W-1:0] cur_ptr_i,
  input  logic [ADDR_W-1:0] tail_ptr_i,
  input  logic              s_tvalid_i,
  input  logic              s_tlast_i,
  input  logic [WORD_W-1:0] s_tdata_i,
  output logic              s_tready_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic              mem_ack_i,
  output logic              app_cap_o,
  output logic [SEL_W-1:0]  app_sel_o,
  input  logic [WORD_W-1:0] app_word_i,
  output logic              cnt_clr_o,
  output logic              cnt_inc_o,
  input  logic [LEN_W-1:0]  cnt_i,
  input  logic              cnt_last_i,
  output logic [LEN_W-1:0]  len_o,
  output logic              done_o,
  output logic              idle_set_o,
  output logic              ptr_adv_o,
  output logic [ADDR_W-1:0] next_ptr_o
);
  localparam logic [IDX_W-1:0] IDX_STAT = IDX_W'(W_STAT);
  localparam logic [IDX_W-1:0] IDX_APPL = IDX_W'(APP_N - 1);

  rxdw_state_e       state_q, state_d;
  logic [ADDR_W-1:0] cur_q, nxt_q, buf_q;
  logic [LEN_W-1:0]  len_q;
  logic [IDX_W-1:0]  widx_q;
  logic              sof_q, eof_q;
  logic              at_tail;
  logic [WORD_W-1:0] stat_w;
  logic [IDX_W:0]    app_idx;

  function automatic logic [ADDR_W-1:0] word_addr(input logic [ADDR_W-1:0] base,
                                                  input logic [IDX_W:0]    idx);
    return base + (ADDR_W'(idx) << 2);
  endfunction

  assign at_tail    = (cur_q == tail_ptr_i);
  assign app_idx    = {1'b0, widx_q} + (IDX_W+1)'(W_APP0);
  assign app_sel_o  = widx_q[SEL_W-1:0];
  assign len_o      = len_q;
  assign next_ptr_o = nxt_q;

  always_comb begin
    stat_w           = '0;
    stat_w[DONE_BIT] = 1'b1;
    stat_w[SOF_BIT]  = sof_q;
    stat_w[EOF_BIT]  = eof_q;
    stat_w[LEN_W-1:0] = cnt_i;
  end

  always_comb begin
    state_d     = state_q;
    s_tready_o  = 1'b0;
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = cur_q;
    mem_wdata_o = '0;
    app_cap_o   = 1'b0;
    cnt_clr_o   = 1'b0;
    cnt_inc_o   = 1'b0;
    done_o      = 1'b0;
    idle_set_o  = 1'b0;
    ptr_adv_o   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (!run_i || idle_i) begin
          s_tready_o = 1'b1;
          if (s_tvalid_i && !s_tlast_i) state_d = ST_DROP;
        end else if (s_tvalid_i) begin
          app_cap_o = 1'b1;
          state_d   = ST_FETCH;
        end
      end
      ST_DROP: begin
        s_tready_o = 1'b1;
        if (s_tvalid_i && s_tlast_i) state_d = ST_IDLE;
      end
      ST_FETCH: begin
        mem_req_o  = 1'b1;
        mem_addr_o = word_addr(cur_q, {1'b0, widx_q});
        if (mem_ack_i && widx_q == IDX_STAT) begin
          if (mem_rdata_i[DONE_BIT]) begin
            idle_set_o = 1'b1;
            state_d    = ST_DROP;
          end else begin
            cnt_clr_o = 1'b1;
            state_d   = ST_DATA;
          end
        end
      end
      ST_DATA: begin
        mem_req_o   = s_tvalid_i;
        mem_we_o    = 1'b1;
        mem_addr_o  = buf_q + (ADDR_W'(cnt_i) << 2);
        mem_wdata_o = s_tdata_i;
        s_tready_o  = mem_ack_i;
        if (s_tvalid_i && mem_ack_i) begin
          cnt_inc_o = 1'b1;
          if (s_tlast_i)       state_d = ST_APP;
          else if (cnt_last_i) state_d = ST_STAT;
        end
      end
      ST_APP: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = word_addr(cur_q, app_idx);
        mem_wdata_o = app_word_i;
        if (mem_ack_i && widx_q == IDX_APPL) state_d = ST_STAT;
      end
      ST_STAT: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = word_addr(cur_q, (IDX_W+1)'(W_STAT));
        mem_wdata_o = stat_w;
        if (mem_ack_i) state_d = ST_ADV;
      end
      ST_ADV: begin
        ptr_adv_o  = 1'b1;
        done_o     = eof_q;
        idle_set_o = at_tail;
        if (eof_q)        state_d = ST_IDLE;
        else if (at_tail) state_d = ST_DROP;
        else              state_d = ST_FETCH;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      nxt_q   <= '0;
      buf_q   <= '0;
      len_q   <= '0;
      widx_q  <= '0;
      sof_q   <= 1'b0;
      eof_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_d != state_q)
        widx_q <= '0;
      else if ((state_q == ST_FETCH || state_q == ST_APP) && mem_ack_i)
        widx_q <= widx_q + 1'b1;
      if (app_cap_o) begin
        cur_q <= cur_ptr_i;
        sof_q <= 1'b1;
        eof_q <= 1'b0;
      end
      if (state_q == ST_FETCH && mem_ack_i) begin
        if (widx_q == IDX_W'(W_NEXT)) nxt_q <= mem_rdata_i[ADDR_W-1:0];
        if (widx_q == IDX_W'(W_BUF))  buf_q <= mem_rdata_i[ADDR_W-1:0];
        if (widx_q == IDX_W'(W_CTRL)) len_q <= mem_rdata_i[LEN_W-1:0];
      end
      if (cnt_inc_o && s_tlast_i) eof_q <= 1'b1;
      if (state_q == ST_ADV) begin
        cur_q <= nxt_q;
        sof_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rx_desc_writer.sv
module rx_desc_writer
  import rxdw_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LEN_W  = 23,
  parameter int unsigned APP_N  = 5
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    run_i,
  input  logic                    idle_i,
  input  logic [ADDR_W-1:0]       cur_ptr_i,
  input  logic [ADDR_W-1:0]       tail_ptr_i,
  input  logic                    s_tvalid_i,
  output logic                    s_tready_o,
  input  logic [31:0]             s_tdata_i,
  input  logic                    s_tlast_i,
  input  logic [APP_N*32-1:0]     app_words_i,
  output logic                    mem_req_o,
  output logic                    mem_we_o,
  output logic [ADDR_W-1:0]       mem_addr_o,
  output logic [31:0]             mem_wdata_o,
  input  logic [31:0]             mem_rdata_i,
  input  logic                    mem_ack_i,
  output logic                    done_o,
  output logic                    idle_set_o,
  output logic                    ptr_adv_o,
  output logic [ADDR_W-1:0]       next_ptr_o
);
  localparam int unsigned SEL_W = $clog2(APP_N);

  logic              app_cap;
  logic [SEL_W-1:0]  app_sel;
  logic [WORD_W-1:0] app_word;
  logic              cnt_clr, cnt_inc, cnt_last;
  logic [LEN_W-1:0]  cnt, len;

  rxdw_app_store #(.APP_N(APP_N), .WORD_W(WORD_W)) u_app (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (app_cap),
    .app_i  (app_words_i),
    .sel_i  (app_sel),
    .word_o (app_word)
  );

  rxdw_chunk_ctr #(.LEN_W(LEN_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (cnt_clr),
    .inc_i   (cnt_inc),
    .limit_i (len),
    .count_o (cnt),
    .last_o  (cnt_last)
  );

  rxdw_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .APP_N(APP_N)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run_i),
    .idle_i      (idle_i),
    .cur_ptr_i   (cur_ptr_i),
    .tail_ptr_i  (tail_ptr_i),
    .s_tvalid_i  (s_tvalid_i),
    .s_tlast_i   (s_tlast_i),
    .s_tdata_i   (s_tdata_i),
    .s_tready_o  (s_tready_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i),
    .mem_ack_i   (mem_ack_i),
    .app_cap_o   (app_cap),
    .app_sel_o   (app_sel),
    .app_word_i  (app_word),
    .cnt_clr_o   (cnt_clr),
    .cnt_inc_o   (cnt_inc),
    .cnt_i       (cnt),
    .cnt_last_i  (cnt_last),
    .len_o       (len),
    .done_o      (done_o),
    .idle_set_o  (idle_set_o),
    .ptr_adv_o   (ptr_adv_o),
    .next_ptr_o  (next_ptr_o)
  );
endmodule

// File: rtl/rx_desc_writer_chk.sv
module rx_desc_writer_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic s_tready_o,
  input logic mem_req_o,
  input logic mem_we_o,
  input logic mem_ack_i,
  input logic wdata_msb,
  input logic rdata_msb,
  input logic done_o,
  input logic idle_set_o,
  input logic ptr_adv_o
);
  // R8: no beat taken during a descriptor read
  assert_no_read_accept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |-> !s_tready_o);

  // R5: completion only together with the pointer update
  assert_done_with_adv_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ptr_adv_o);

  // R6: a done-flagged write completes right before each advance
  assert_status_before_adv_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_adv_o |-> $past(mem_req_o && mem_we_o && mem_ack_i && wdata_msb));

  // R7: advance is a single-cycle pulse
  assert_adv_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_adv_o |=> !ptr_adv_o);

  // R2: idle without advance only on a read returning a done descriptor
  assert_done_skip_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_set_o && !ptr_adv_o) |-> (mem_req_o && !mem_we_o && mem_ack_i && rdata_msb));
endmodule

bind rx_desc_writer rx_desc_writer_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .s_tready_o (s_tready_o),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_ack_i  (mem_ack_i),
  .wdata_msb  (mem_wdata_o[31]),
  .rdata_msb  (mem_rdata_i[31]),
  .done_o     (done_o),
  .idle_set_o (idle_set_o),
  .ptr_adv_o  (ptr_adv_o)
);

// File: tb/rx_desc_writer_bench.sv
`timescale 1ns/1ps
module rx_desc_writer_bench;
  localparam int APP_N = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic              run, s_tvalid, s_tready, s_tlast;
  logic [31:0]       tail_ptr, s_tdata;
  logic [APP_N*32-1:0] app;
  logic              mem_req, mem_we, mem_ack;
  logic [31:0]       mem_addr, mem_wdata, mem_rdata;
  logic              done, idle_set, ptr_adv;
  logic [31:0]       next_ptr;

  logic [31:0] mem [256];
  logic [31:0] cur_r;
  logic        idle_r;
  logic        host_we = 1'b0, set_cur = 1'b0, clr_idle = 1'b0;
  logic [31:0] host_addr = '0, host_data = '0, cur_val = '0;

  rx_desc_writer u_rx_desc_writer (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .idle_i(idle_r),
    .cur_ptr_i(cur_r), .tail_ptr_i(tail_ptr),
    .s_tvalid_i(s_tvalid), .s_tready_o(s_tready), .s_tdata_i(s_tdata),
    .s_tlast_i(s_tlast), .app_words_i(app),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack),
    .done_o(done), .idle_set_o(idle_set), .ptr_adv_o(ptr_adv),
    .next_ptr_o(next_ptr)
  );

  assign mem_ack   = mem_req;
  assign mem_rdata = mem[mem_addr[9:2]];

  // memory plus the register block's pointer and idle state
  always @(posedge clk) begin
    if (host_we) mem[host_addr[9:2]] <= host_data;
    if (mem_req && mem_we && mem_ack) mem[mem_addr[9:2]] <= mem_wdata;
    if (!rst_n) begin
      cur_r  <= '0;
      idle_r <= 1'b0;
    end else begin
      if (set_cur)      cur_r <= cur_val;
      else if (ptr_adv) cur_r <= next_ptr;
      if (clr_idle)      idle_r <= 1'b0;
      else if (idle_set) idle_r <= 1'b1;
    end
  end

  // scoreboard
  logic [31:0] q_addr[$], q_data[$];
  string       q_tag[$];
  int mon_checks = 0, mon_errs = 0;
  int done_cnt = 0, idle_cnt = 0, both_cnt = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req && mem_we && mem_ack) begin
        mon_checks++;
        if (q_addr.size() == 0) begin
          mon_errs++;
          $display("FAIL R1 unexpected write addr act %h exp none", mem_addr);
        end else begin
          logic [31:0] ea, ed;
          string t;
          ea = q_addr.pop_front(); ed = q_data.pop_front(); t = q_tag.pop_front();
          if (mem_addr !== ea || mem_wdata !== ed) begin
            mon_errs++;
            $display("FAIL %s write act %h:%h exp %h:%h", t, mem_addr, mem_wdata, ea, ed);
          end
        end
      end
      if (s_tvalid && s_tready && mem_req && !mem_we) begin
        mon_errs++;
        $display("FAIL R8 beat accepted during read act 1 exp 0");
      end
      if (done) done_cnt++;
      if (idle_set) idle_cnt++;
      if (done && idle_set) both_cnt++;
    end
  end

  int checks = 0, errs = 0;
  bit finished = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act %h exp %h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); host_we = 1'b1; host_addr = a; host_data = d;
    @(negedge clk); host_we = 1'b0;
  endtask

  task automatic desc(input logic [31:0] p, input logic [31:0] nx,
                      input logic [31:0] b, input logic [31:0] len);
    host_wr(p, nx); host_wr(p + 4, b); host_wr(p + 8, len); host_wr(p + 12, 0);
  endtask

  task automatic put_cur(input logic [31:0] v);
    @(negedge clk); set_cur = 1'b1; cur_val = v;
    @(negedge clk); set_cur = 1'b0;
  endtask

  task automatic idle_off();
    @(negedge clk); clr_idle = 1'b1;
    @(negedge clk); clr_idle = 1'b0;
  endtask

  function automatic logic [31:0] app_word(input logic [15:0] seed, input int j);
    return {seed, 16'hA000 | 16'(j)};
  endfunction

  // walks the chain in memory and queues the writes the design must make
  task automatic expect_pkt(input int n, input logic [15:0] seed,
                            output int e_done, output int e_idle, output logic [31:0] e_cur);
    logic [31:0] p, bufa, nx, st;
    int rem, len, ch;
    bit sof, last;
    p = cur_r; rem = n; sof = 1'b1; e_done = 0; e_idle = 0;
    while (rem > 0) begin
      st = mem[p[9:2] + 3];
      if (st[31]) begin e_idle = 1; break; end
      nx   = mem[p[9:2]];
      bufa = mem[p[9:2] + 1];
      len  = int'(mem[p[9:2] + 2][22:0]);
      ch   = (len < rem) ? len : rem;
      for (int i = 0; i < ch; i++) begin
        q_addr.push_back(bufa + 32'(4 * i));
        q_data.push_back({seed, 16'(n - rem + i)});
        q_tag.push_back("R3");
      end
      rem -= ch;
      if (rem == 0) begin
        for (int j = 0; j < APP_N; j++) begin
          q_addr.push_back(p + 32'(16 + 4 * j));
          q_data.push_back(app_word(seed, j));
          q_tag.push_back("R5/R9");
        end
        e_done = 1;
      end
      q_addr.push_back(p + 12);
      q_data.push_back(32'h8000_0000 | (32'(sof) << 27) | (32'(rem == 0) << 26) | 32'(ch));
      q_tag.push_back("R4/R6");
      sof = 1'b0;
      last = (p == tail_ptr);
      p = nx;
      if (last) begin e_idle = 1; break; end
    end
    e_cur = p;
  endtask

  task automatic send_pkt(input int n, input logic [15:0] seed);
    @(negedge clk);
    for (int k = 0; k < n; k++) begin
      bit ok;
      s_tvalid = 1'b1;
      s_tdata  = {seed, 16'(k)};
      s_tlast  = (k == n - 1);
      if (k == 0)
        for (int j = 0; j < APP_N; j++) app[j*32 +: 32] = app_word(seed, j);
      do begin
        #1 ok = s_tready;
        @(negedge clk);
      end while (!ok);
      if (k == 0) app = '1;
    end
    s_tvalid = 1'b0;
    s_tlast  = 1'b0;
  endtask

  task automatic run_pkt(input string tag, input int n, input logic [15:0] seed);
    int d0, i0, ed, ei;
    logic [31:0] ec;
    d0 = done_cnt; i0 = idle_cnt;
    expect_pkt(n, seed, ed, ei, ec);
    send_pkt(n, seed);
    repeat (30) @(negedge clk);
    check({tag, " writes left"}, 32'(q_addr.size()), 0);
    check({tag, " done pulses"}, 32'(done_cnt - d0), 32'(ed));
    check({tag, " idle pulses"}, 32'(idle_cnt - i0), 32'(ei));
    check({tag, " R7 pointer"}, cur_r, ec);
  endtask

  task automatic run_drop(input string tag, input int n);
    int d0, i0;
    logic [31:0] c0;
    d0 = done_cnt; i0 = idle_cnt; c0 = cur_r;
    send_pkt(n, 16'hDEAD);
    repeat (20) @(negedge clk);
    check({tag, " done pulses"}, 32'(done_cnt - d0), 0);
    check({tag, " idle pulses"}, 32'(idle_cnt - i0), 0);
    check({tag, " pointer"}, cur_r, c0);
  endtask

  localparam logic [31:0] D0 = 32'h000, D1 = 32'h040, D2 = 32'h080, D3 = 32'h0C0;

  initial begin
    run = 1'b0; s_tvalid = 1'b0; s_tlast = 1'b0; s_tdata = '0; app = '0;
    tail_ptr = D3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 mem_req", 32'(mem_req), 0);
    check("R10 done", 32'(done), 0);
    check("R10 idle_set", 32'(idle_set), 0);
    check("R10 ptr_adv", 32'(ptr_adv), 0);

    desc(D0, D1, 32'h200, 8);
    desc(D1, D2, 32'h280, 3);
    desc(D2, D3, 32'h300, 4);
    desc(D3, D0, 32'h380, 4);
    put_cur(D0);
    run = 1'b1;

    run_pkt("R3 single", 5, 16'h1111);
    run_pkt("R4 split", 6, 16'h2222);
    // exact fill of the tail descriptor: completion and idle together
    run_pkt("R7 tail eof", 4, 16'h3333);
    check("R7 coincident pulses", 32'(both_cnt), 1);
    check("R7 idle reg", 32'(idle_r), 1);

    run_drop("R1 idle", 3);
    idle_off();
    run = 1'b0;
    run_drop("R1 stopped", 4);
    run = 1'b1;

    // D0 still holds a done status from the first packet
    run_pkt("R2 done desc", 3, 16'h4444);
    check("R2 idle reg", 32'(idle_r), 1);
    idle_off();

    desc(D0, D1, 32'h200, 2);
    tail_ptr = D0;
    run_pkt("R7 tail mid", 5, 16'h5555);
    idle_off();

    host_wr(D1 + 12, 0);
    host_wr(D2 + 12, 0);
    tail_ptr = D3;
    run_pkt("R3 clamp", 4, 16'h6666);
    check("R5 total done", 32'(done_cnt), 4);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks + mon_checks, errs + mon_errs);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      $display("FAIL watchdog act timeout exp finish");
      $display("CHECKS %0d ERRORS %0d", checks + mon_checks + 1, errs + mon_errs + 1);
      $finish;
    end
  end
endmodule